// File: doc/BRIEF.md
# Dual-Register Edge Input Capture

This block snapshots a free-running counter when a chosen transition appears on an external pin. The pin is first brought into the local clock domain, then its transitions are qualified against a two-bit edge mode. Each qualifying transition copies the counter into the next free capture register: the first goes into slot one, the second into slot two. Once both slots are filled, further transitions are dropped until software re-arms the sequence.

A one-cycle event strobe marks the end of a sequence. A select bit decides whether that is after the first capture or after the second. The sequence is re-armed in two ways: by a strobe that stands for software clearing the capture status, or by the edge mode moving from off to any active setting. The capture registers are read-only. Bus writes aimed at them are accepted on the port and have no effect.

Top module: `edge_capture_pair`

## Requirements
- R1: `mode_i` selects the qualifying transition of the synchronized pin: 0 = none, 1 = low-to-high, 2 = high-to-low, 3 = either. With mode 0 no capture ever happens.
- R2: Captures and event strobes happen only while `pin_is_input_i` is 1. Transitions seen while it is 0 are dropped and do not use up a slot.
- R3: A pin level first sampled at rising edge k is seen by the edge logic after edge k+1. A qualifying transition therefore loads `count_i`, as sampled at edge k+2, into a capture register at edge k+2.
- R4: The first capture of a sequence goes into `cap1_o` and the second into `cap2_o`. The other register keeps its value.
- R5: After two captures, qualifying transitions change neither capture register and raise no event, until the sequence is re-armed.
- R6: `event_o` is high for exactly the one cycle after the capture that ends the sequence. That is the first capture when `second_sel_i` is 0 and the second capture when it is 1.
- R7: A cycle with `rearm_i` high resets the capture count to zero. A qualifying transition that lands on that same edge is dropped.
- R8: The capture count resets to zero one cycle after `mode_i` changes from 0 to a nonzero value.
- R9: After reset both capture registers read zero and `event_o` is low.
- R10: Writes on `cap_wr_i` (bit 0 addresses slot one, bit 1 addresses slot two) with any `cap_wdata_i` leave both capture registers and the capture count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external pin |
| count_i | input | CNT_W | Counter value to capture |
| mode_i | input | 2 | Edge mode |
| pin_is_input_i | input | 1 | Pin direction, 1 = input (capture enabled) |
| second_sel_i | input | 1 | 0 = event after first capture, 1 = after second |
| rearm_i | input | 1 | Re-arm strobe (capture status cleared) |
| cap_wr_i | input | 2 | Write strobes aimed at the two capture registers |
| cap_wdata_i | input | CNT_W | Write data for those strobes (ignored) |
| cap1_o | output | CNT_W | First capture register |
| cap2_o | output | CNT_W | Second capture register |
| event_o | output | 1 | One-cycle capture event strobe |

## Verification
The bench builds the block with its defaults: a 32-bit counter and a two-stage synchronizer. The full width lets random counter values reach the top bit of both registers. With the default stage count, the three-edge latency of R3 can be hit exactly, so a re-arm strobe can be placed on the same edge as a capture. Random sequences mix the four modes with direction flips, select changes, re-arms and ignored writes, which carries sequences into the filled state and back out.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        EM_OFF  = 2'd0,
        EM_RISE = 2'd1,
        EM_FALL = 2'd2,
        EM_BOTH = 2'd3
    } edge_mode_e;

    localparam int unsigned SLOTS = 2;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge_qual.sv
module cap_edge_qual
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic [1:0] mode_i,
    output logic       hit_o
);
    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d = lvl_i;
        rise   = lvl_i & ~prev_q;
        fall   = ~lvl_i & prev_q;
        unique case (edge_mode_e'(mode_i))
            EM_RISE: hit_o = rise;
            EM_FALL: hit_o = fall;
            EM_BOTH: hit_o = rise | fall;
            default: hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/edge_capture_pair.sv
module edge_capture_pair
    import cap_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       mode_i,
    input  logic             pin_is_input_i,
    input  logic             second_sel_i,
    input  logic             rearm_i,
    input  logic [1:0]       cap_wr_i,
    input  logic [CNT_W-1:0] cap_wdata_i,
    output logic [CNT_W-1:0] cap1_o,
    output logic [CNT_W-1:0] cap2_o,
    output logic             event_o
);
    localparam int unsigned NUM_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cap1;
        logic [CNT_W-1:0] cap2;
        logic [NUM_W-1:0] num;
        logic             evt;
        logic             mode_on;
    } state_t;

    state_t st_d, st_q;
    logic   lvl_sync;
    logic   hit;
    logic   arm;

    // Bus writes to the capture slots are accepted and discarded.
    logic unused_wr;
    assign unused_wr = ^{cap_wr_i, cap_wdata_i};

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (lvl_sync)
    );

    cap_edge_qual u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_sync),
        .mode_i (mode_i),
        .hit_o  (hit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.evt     = 1'b0;
        st_d.mode_on = (mode_i != EM_OFF);
        arm          = rearm_i | (!st_q.mode_on && (mode_i != EM_OFF));
        if (arm) begin
            st_d.num = '0;
        end else if (hit && pin_is_input_i && (st_q.num < NUM_W'(SLOTS))) begin
            if (st_q.num == '0) st_d.cap1 = count_i;
            else                st_d.cap2 = count_i;
            st_d.evt = (st_q.num == NUM_W'(second_sel_i));
            st_d.num = st_q.num + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap1_o  = st_q.cap1;
    assign cap2_o  = st_q.cap2;
    assign event_o = st_q.evt;
endmodule

// File: rtl/edge_capture_pair_chk.sv
module edge_capture_pair_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             pin_is_input_i,
    input logic [CNT_W-1:0] cap1_o,
    input logic [CNT_W-1:0] cap2_o,
    input logic             event_o
);
    AST_OFF_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0) |=> ($stable(cap1_o) && $stable(cap2_o))); // R1

    AST_OUTPUT_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_is_input_i |=> ($stable(cap1_o) && $stable(cap2_o))); // R2

    AST_EVENT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(event_o) |-> $past(pin_is_input_i)); // R2

    AST_EVENT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(event_o) |-> ($past(mode_i) != 2'd0)); // R1

    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o); // R6
endmodule

bind edge_capture_pair edge_capture_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode_i),
    .pin_is_input_i (pin_is_input_i),
    .cap1_o         (cap1_o),
    .cap2_o         (cap2_o),
    .event_o        (event_o)
);

// File: tb/sim_edge_capture_pair.sv
module sim_edge_capture_pair;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin_i = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic [1:0]       mode_i = 2'd0;
    logic             pin_is_input_i = 1'b0;
    logic             second_sel_i = 1'b0;
    logic             rearm_i = 1'b0;
    logic [1:0]       cap_wr_i = 2'b00;
    logic [CNT_W-1:0] cap_wdata_i = '0;
    logic [CNT_W-1:0] cap1_o, cap2_o;
    logic             event_o;

    int checks = 0;
    int errors = 0;
    int ev_seen = 0;
    bit done = 0;

    // model state
    logic             m_lvl = 1'b0;
    logic [CNT_W-1:0] m_c1 = '0, m_c2 = '0;
    int               m_num = 0;
    int               m_ev = 0;

    always #2 clk = ~clk;

    edge_capture_pair u0 (.*);

    always @(negedge clk) if (rst_n && event_o) ev_seen++;

    function automatic bit qual(input logic [1:0] m, input logic o, input logic n);
        case (m)
            2'd1: return !o && n;
            2'd2: return o && !n;
            2'd3: return o != n;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " cap1"}, cap1_o, m_c1);
        chk({req, " cap2"}, cap2_o, m_c2);
        chk({req, " events"}, CNT_W'(ev_seen), CNT_W'(m_ev));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic toggle(input logic [CNT_W-1:0] cv);
        logic nl;
        nl = ~m_lvl;
        count_i = cv;
        pin_i = nl;
        if (qual(mode_i, m_lvl, nl) && pin_is_input_i && m_num < 2) begin
            if (m_num == 0) m_c1 = cv; else m_c2 = cv;
            if (m_num == int'(second_sel_i)) m_ev++;
            m_num++;
        end
        m_lvl = nl;
        idle(5);
    endtask

    task automatic set_mode(input logic [1:0] nm);
        if (mode_i == 2'd0 && nm != 2'd0) m_num = 0;
        mode_i = nm;
        idle(3);
    endtask

    task automatic rearm();
        rearm_i = 1'b1;
        @(negedge clk);
        rearm_i = 1'b0;
        m_num = 0;
        idle(2);
    endtask

    task automatic bus_write(input logic [1:0] w, input logic [CNT_W-1:0] d);
        cap_wr_i = w;
        cap_wdata_i = d;
        @(negedge clk);
        cap_wr_i = 2'b00;
        idle(2);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle(3);
        // R9: reset state
        chk("R9 cap1 reset", cap1_o, '0);
        chk("R9 cap2 reset", cap2_o, '0);
        chk("R9 event reset", CNT_W'(event_o), '0);
        rst_n = 1'b1;
        idle(2);

        // R1: mode off ignores edges
        pin_is_input_i = 1'b1;
        toggle(32'h11);
        toggle(32'h12);
        check_all("R1 mode off");

        // R3/R4/R6: rising, event on first
        set_mode(2'd1);
        toggle(32'hA0000001);
        check_all("R3 R4 R6 first rise");
        toggle(32'h22);
        toggle(32'hB0000002);
        check_all("R4 second rise");
        // R5: full, further edges dropped
        toggle(32'h33);
        toggle(32'h44);
        check_all("R5 full");

        // R10: writes ignored, also count untouched
        bus_write(2'b11, 32'hDEADBEEF);
        check_all("R10 write ignored");
        toggle(32'h55);
        toggle(32'h66);
        check_all("R10 count kept");

        // R7: rearm, second select
        second_sel_i = 1'b1;
        rearm();
        set_mode(2'd2);
        toggle(32'h7);
        toggle(32'h8);
        check_all("R7 R6 fall first");
        toggle(32'h9);
        toggle(32'hA);
        check_all("R6 sel1 event on second");

        // R2: output direction drops edges
        rearm();
        pin_is_input_i = 1'b0;
        set_mode(2'd3);
        toggle(32'hC1);
        toggle(32'hC2);
        check_all("R2 output dir");
        pin_is_input_i = 1'b1;
        toggle(32'hC3);
        check_all("R2 input again");

        // R8: off -> active re-arms
        toggle(32'hC4);
        toggle(32'hC5);
        check_all("R8 full before");
        set_mode(2'd0);
        set_mode(2'd3);
        toggle(32'hD1);
        check_all("R8 rearmed by mode");

        // R7: rearm on the same edge as a capture drops it
        toggle(32'hD2);
        count_i = 32'hE1;
        pin_i = ~m_lvl;
        m_lvl = ~m_lvl;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rearm_i = 1'b1;
        @(negedge clk);
        rearm_i = 1'b0;
        m_num = 0;
        idle(3);
        check_all("R7 same-edge drop");
        toggle(32'hE2);
        check_all("R7 next goes to cap1");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1, 2, 3: toggle($urandom());
                4: set_mode(2'($urandom_range(0, 3)));
                5: rearm();
                6: begin second_sel_i = 1'($urandom()); idle(1); end
                7: begin pin_is_input_i = ($urandom_range(0, 4) != 0); idle(1); end
                default: bus_write(2'($urandom()), $urandom());
            endcase
            check_all("R3 R4 R5 R6 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule